// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block runs complete transactions on a three-wire serial EEPROM (chip select, serial clock, serial data out, serial data in) on behalf of a host. The host pulses a command strobe together with an operation code, a 6-bit word address and a 16-bit write word. The block then frames the transfer: it raises chip select, shifts out a 3-bit opcode and the address MSB first, and either shifts out a data word, shifts in a data word, or stops after the header. When chip select drops again the block pulses `done`, and for a read it presents the captured word on `rdata`.

The serial clock rate is set by `half_period`, the number of system clocks spent in each high phase and in each low phase of the serial clock. The value is taken when a command is accepted, so the host may change it at any time without disturbing a transfer in flight. The block does not wait for the memory's internal programming cycle. The host paces successive writes itself.

Top module: `eem_master`

## Requirements
- R1: A synchronous active-high `rst` drives `ee_cs`, `ee_sck`, `ee_do`, `busy`, `done` and `rdata` to zero within one clock, including in the middle of a transfer.
- R2: `ee_cs` rises while `ee_sck` is low, one low phase before the first clock pulse. It falls one low phase after the last falling clock edge. `done` is high for exactly the one cycle in which `ee_cs` is first seen low. `busy` equals `ee_cs` throughout.
- R3: Every outgoing bit is placed on `ee_do` while `ee_sck` is low, and `ee_do` holds steady while `ee_sck` is high. The bit the memory receives is the value of `ee_do` at a rising clock edge.
- R4: Let H be `half_period`, taken as 1 when it is 0, and latched when the command is accepted. Every high phase and every low phase lasts H system clocks. A frame of N pulses keeps `ee_cs` high for (2N+1)·H clocks.
- R5: `cmd_op` = 2'b00 (write enable) sends 9 pulses carrying 1,0,0 followed by six 1 bits. `cmd_addr` and `cmd_wdata` are ignored.
- R6: `cmd_op` = 2'b01 (write) sends 25 pulses: 1,0,1, then `cmd_addr` MSB first, then `cmd_wdata` MSB first.
- R7: `cmd_op` = 2'b10 (read) sends 1,0 … that is 1,1,0, then `cmd_addr` MSB first, then 16 more pulses with `ee_do` low. For each of those 16 pulses, `ee_di` is sampled one system clock after the pulse's falling edge, MSB first. The word appears on `rdata` together with `done`.
- R8: `rdata` changes only when a read completes. Write and write-enable transfers leave it unchanged.
- R9: A strobe that arrives while `busy` is high is dropped and is not queued. A strobe with `cmd_op` = 2'b11 starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 write enable, 01 write, 10 read, 11 no operation |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Word to write |
| half_period | input | DIV_W | System clocks per serial-clock half period (0 acts as 1) |
| rdata | output | 16 | Last word read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| ee_cs | output | 1 | Memory chip select |
| ee_sck | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the memory |
| ee_di | input | 1 | Serial data from the memory |

## Verification
The hardest case to reach is a read with a one-clock half period. There, the sample of the final data bit falls in the same cycle in which the transfer ends, and it must still reach `rdata`. Directed reads with `half_period` of 0 and 1 and with alternating end bits cover this case. Random reads at longer periods cover the ordinary spacing. The bench also fires a second strobe partway through a busy transfer and changes `half_period` after acceptance. A behavioural memory model answers read data on each rising clock, so any mis-timed sample shows up as a wrong bit.

// File: rtl/eem_pkg.sv
package eem_pkg;
  localparam int OPC_W   = 3;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = OPC_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int SLOT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_WREN  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } ee_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } ee_st_e;

  localparam logic [OPC_W-1:0] OPC_WREN  = 3'b100;
  localparam logic [OPC_W-1:0] OPC_WRITE = 3'b101;
  localparam logic [OPC_W-1:0] OPC_READ  = 3'b110;

  // Outgoing bits, left aligned: the first bit sent is the MSB.
  function automatic logic [FRAME_W-1:0] build_frame(input ee_op_e op,
                                                     input logic [ADDR_W-1:0] a,
                                                     input logic [DATA_W-1:0] d);
    case (op)
      OP_WREN:  return {OPC_WREN, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
      OP_WRITE: return {OPC_WRITE, a, d};
      OP_READ:  return {OPC_READ, a, {DATA_W{1'b0}}};
      default:  return '0;
    endcase
  endfunction

  // Number of clock pulses in the frame.
  function automatic logic [SLOT_W-1:0] frame_slots(input ee_op_e op);
    return (op == OP_WREN) ? SLOT_W'(HDR_W) : SLOT_W'(FRAME_W);
  endfunction
endpackage

// File: rtl/eem_phase_timer.sv
module eem_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] h);
    return (h == '0) ? DIV_W'(1) : h;
  endfunction

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= DIV_W'(1);
    end else if (load) begin
      reload <= eff_half(half);
      cnt    <= eff_half(half) - DIV_W'(1);
    end else if (run) begin
      cnt <= tick ? reload - DIV_W'(1) : cnt - DIV_W'(1);
    end
  end
endmodule

// File: rtl/eem_shifter.sv
module eem_shifter #(
  parameter int FRAME_W = 25,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  input  logic               smp,
  input  logic               di,
  output logic               next_bit,
  output logic [DATA_W-1:0]  rx_next
);
  logic [FRAME_W-1:0] tx;
  logic [DATA_W-1:0]  rx;

  assign next_bit = tx[FRAME_W-2];
  assign rx_next  = smp ? {rx[DATA_W-2:0], di} : rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (load)       tx <= frame;
      else if (shift) tx <= {tx[FRAME_W-2:0], 1'b0};
      rx <= load ? '0 : rx_next;
    end
  end
endmodule

// File: rtl/eem_master.sv
module eem_master #(
  parameter int DIV_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [eem_pkg::ADDR_W-1:0] cmd_addr,
  input  logic [eem_pkg::DATA_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]           half_period,
  output logic [eem_pkg::DATA_W-1:0] rdata,
  output logic                       busy,
  output logic                       done,
  output logic                       ee_cs,
  output logic                       ee_sck,
  output logic                       ee_do,
  input  logic                       ee_di
);
  import eem_pkg::*;

  ee_st_e              state;
  logic [SLOT_W-1:0]   slots;
  logic                rd_op;
  logic                smp_pend;
  logic                phase_tick;
  logic                tx_next;
  logic [DATA_W-1:0]   rx_next;
  logic [FRAME_W-1:0]  frame_w;
  ee_op_e              op_in;

  // Named internal events
  logic start_acc, bit_done, last_bit, frame_end, in_slot;

  assign op_in     = ee_op_e'(cmd_op);
  assign frame_w   = build_frame(op_in, cmd_addr, cmd_wdata);
  assign start_acc = cmd_valid && (state == ST_IDLE) && (op_in != OP_NONE);
  assign bit_done  = (state == ST_HIGH) && phase_tick;
  assign last_bit  = bit_done && (slots == '0);
  assign frame_end = (state == ST_TAIL) && phase_tick;
  assign in_slot   = rd_op && (slots < SLOT_W'(DATA_W));
  assign busy      = (state != ST_IDLE);

  eem_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (start_acc),
    .run  (busy),
    .half (half_period),
    .tick (phase_tick)
  );

  eem_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (start_acc),
    .frame    (frame_w),
    .shift    (bit_done),
    .smp      (smp_pend),
    .di       (ee_di),
    .next_bit (tx_next),
    .rx_next  (rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ee_cs    <= 1'b0;
      ee_sck   <= 1'b0;
      ee_do    <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      slots    <= '0;
      rd_op    <= 1'b0;
      smp_pend <= 1'b0;
    end else begin
      done     <= 1'b0;
      smp_pend <= bit_done && in_slot;
      case (state)
        ST_IDLE: if (start_acc) begin
          state  <= ST_LOW;
          ee_cs  <= 1'b1;
          ee_sck <= 1'b0;
          ee_do  <= frame_w[FRAME_W-1];
          slots  <= frame_slots(op_in) - SLOT_W'(1);
          rd_op  <= (op_in == OP_READ);
        end
        ST_LOW: if (phase_tick) begin
          state  <= ST_HIGH;
          ee_sck <= 1'b1;
        end
        ST_HIGH: if (bit_done) begin
          ee_sck <= 1'b0;
          ee_do  <= tx_next;
          if (last_bit) state <= ST_TAIL;
          else begin
            state <= ST_LOW;
            slots <= slots - SLOT_W'(1);
          end
        end
        default: if (frame_end) begin
          state <= ST_IDLE;
          ee_cs <= 1'b0;
          ee_do <= 1'b0;
          done  <= 1'b1;
          if (rd_op) rdata <= rx_next;
        end
      endcase
    end
  end
endmodule

// File: rtl/eem_master_chk.sv
module eem_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       ee_cs,
  input logic       ee_sck,
  input logic       ee_do
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!ee_cs && !ee_sck && !ee_do && !done && !busy)); // R1

  AST_SCK_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    ee_sck |-> ee_cs); // R2

  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> !ee_sck); // R2

  AST_SCK_RISE_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sck) |-> $past(ee_cs)); // R2

  AST_DONE_AT_CS_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(ee_cs)); // R2

  AST_CS_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs) |-> done); // R2

  AST_DO_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    ee_sck |-> $stable(ee_do)); // R3

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> $past(cmd_valid && !busy && (cmd_op != 2'b11))); // R9
endmodule

bind eem_master eem_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .ee_cs     (ee_cs),
  .ee_sck    (ee_sck),
  .ee_do     (ee_do)
);

// File: tb/eem_master_tb.sv
module eem_master_tb;
  import eem_pkg::*;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic [DIV_W-1:0] half_period = 8'd1;
  logic [DATA_W-1:0] rdata;
  logic busy, done, ee_cs, ee_sck, ee_do;
  logic ee_di = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] last_rd = '0;

  always #4 clk = ~clk;

  eem_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .half_period(half_period),
    .rdata(rdata), .busy(busy), .done(done), .ee_cs(ee_cs),
    .ee_sck(ee_sck), .ee_do(ee_do), .ee_di(ee_di)
  );

  // Memory model: presents read data bits on rising clock pulses 10..25
  logic [DATA_W-1:0] dev_word = '0;
  int dev_pc = 0;
  always @(posedge ee_cs) dev_pc = 0;
  always @(posedge ee_sck) begin
    dev_pc = dev_pc + 1;
    if (dev_pc >= 10 && dev_pc <= 25) ee_di = dev_word[25 - dev_pc];
  end

  // Port monitor, sampled on falling clock edges
  int pulses, cs_cyc, hi_run, lo_run, phase_bad, do_bad, done_cnt, done_bad, busy_bad, cs_rises;
  int exp_h = 1;
  logic [FRAME_W-1:0] cap;
  logic prev_cs = 1'b0, prev_sck = 1'b0, prev_do = 1'b0;

  task automatic clear_mon();
    pulses = 0; cs_cyc = 0; hi_run = 0; lo_run = 0; phase_bad = 0; do_bad = 0;
    done_cnt = 0; done_bad = 0; busy_bad = 0; cs_rises = 0; cap = '0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ee_cs && !prev_cs) begin
        cs_rises++;
        if (ee_sck) phase_bad++;
      end
      if (busy != ee_cs) busy_bad++;
      if (done) begin
        done_cnt++;
        if (ee_cs || !prev_cs) done_bad++;
      end
      if (ee_cs) begin
        cs_cyc++;
        if (ee_sck) begin
          if (!prev_sck) begin
            pulses++;
            cap = {cap[FRAME_W-2:0], ee_do};
            if (lo_run != exp_h) phase_bad++;
            lo_run = 0;
          end else if (ee_do != prev_do) do_bad++;
          hi_run++;
        end else begin
          if (prev_sck) begin
            if (hi_run != exp_h) phase_bad++;
            hi_run = 0;
          end
          lo_run++;
        end
      end else if (prev_cs) begin
        if (lo_run != exp_h) phase_bad++;
        lo_run = 0;
        hi_run = 0;
      end
    end
    prev_cs = ee_cs; prev_sck = ee_sck; prev_do = ee_do;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] exp_bits(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] d);
    if (op == 2'b00) return {16'h0000, 3'b100, 6'b111111};
    if (op == 2'b01) return {3'b101, a, d};
    return {3'b110, a, 16'h0000};
  endfunction

  task automatic run_txn(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [DIV_W-1:0] hp, input logic [DATA_W-1:0] dw, input bit poke);
    int n, h;
    string rq;
    h  = (hp == 0) ? 1 : int'(hp);
    n  = (op == 2'b00) ? 9 : 25;
    rq = (op == 2'b00) ? "R5" : (op == 2'b01) ? "R6" : "R7";
    @(posedge clk); #2;
    clear_mon();
    exp_h = h; dev_word = dw;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; half_period = hp;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
    half_period = DIV_W'($urandom_range(1, 7));   // R4: must not affect this frame
    cmd_addr = ADDR_W'($urandom); cmd_wdata = DATA_W'($urandom);
    if (poke) begin
      repeat (5) @(posedge clk);
      #2; cmd_valid = 1'b1; cmd_op = 2'b01;
      @(posedge clk); #2; cmd_valid = 1'b0;
    end
    for (int t = 0; t < 4000 && done_cnt == 0; t++) begin
      @(posedge clk); #2;
    end
    chk(rq, "pulse count", pulses, n);
    chk(rq, "serial bits", cap, exp_bits(op, a, d));
    chk("R4", "cs high cycles", cs_cyc, (2 * n + 1) * h);
    chk("R4", "phase length errors", phase_bad, 0);
    chk("R3", "data moved while clock high", do_bad, 0);
    chk("R2", "done pulses", done_cnt, 1);
    chk("R2", "done timing errors", done_bad, 0);
    chk("R2", "busy vs cs", busy_bad, 0);
    repeat (4) @(posedge clk);
    #2;
    chk("R9", "frames started", cs_rises, 1);
    if (op == 2'b10) begin
      last_rd = dw;
      chk("R7", "read word", rdata, last_rd);
    end else chk("R8", "rdata held", rdata, last_rd);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'h00C0FFEE);
    clear_mon();
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "outputs in reset", {ee_cs, ee_sck, ee_do, busy, done}, 0);
    rst = 1'b0;
    @(posedge clk); #2;
    chk("R1", "rdata after reset", rdata, 0);

    // Directed corner cases
    run_txn(2'b00, 6'h00, 16'h1234, 8'd1, 16'h0000, 1'b0);   // R5 address ignored
    run_txn(2'b10, 6'h2A, 16'h0000, 8'd1, 16'h8001, 1'b0);   // R7 one-clock half period
    run_txn(2'b10, 6'h15, 16'h0000, 8'd0, 16'hFFFF, 1'b0);   // R4 zero acts as one
    run_txn(2'b01, 6'h3F, 16'hFFFF, 8'd3, 16'h0000, 1'b0);   // R6
    run_txn(2'b01, 6'h01, 16'h0000, 8'd2, 16'h0000, 1'b1);   // R9 strobe while busy
    run_txn(2'b10, 6'h3F, 16'h0000, 8'd1, 16'h7FFE, 1'b1);   // R7 and R9
    run_txn(2'b00, 6'h15, 16'hAAAA, 8'd4, 16'h0000, 1'b0);   // R8 hold

    // No-operation code starts nothing (R9)
    @(posedge clk); #2;
    clear_mon();
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
    repeat (20) @(posedge clk);
    #2;
    chk("R9", "op 11 frames", cs_rises, 0);
    chk("R9", "op 11 busy", busy, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      run_txn(2'($urandom_range(0, 2)), ADDR_W'($urandom), DATA_W'($urandom),
              DIV_W'($urandom_range(0, 4)), DATA_W'($urandom), ($urandom_range(0, 3) == 0));
    end

    // Reset in the middle of a transfer (R1)
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = 2'b01; half_period = 8'd2;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
    repeat (30) @(posedge clk);
    #2; rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk("R1", "outputs after mid-frame reset", {ee_cs, ee_sck, ee_do, busy, done}, 0);
    chk("R1", "rdata after mid-frame reset", rdata, 0);
    rst = 1'b0;
    last_rd = '0;
    run_txn(2'b10, 6'h07, 16'h0000, 8'd2, 16'h5A3C, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule